// File: doc/BRIEF.md
# Carry-Chained Integer Adder Unit

This block is a 32-bit add/subtract engine for an integer execution pipe. It holds its own one-bit carry flag. Each accepted operation reads two operands and an operation code. One cycle later the block presents a result word, a result-valid pulse, a trap request and the updated carry flag. Operand fetch, stack movement, trap handling and writeback all sit outside the block.

The add/subtract variants differ only in how they treat the carry flag and in what makes them trap:

- Checked operations consume the flag, clear it, and trap on signed overflow.
- Chained operations consume the flag and reload it with the carry or the borrow, so multi-word arithmetic can be built one word at a time. They never trap.
- Plain operations neither read nor write the flag.
- Tagged operations ignore the flag, clear it, and trap when an operand does not look like a small integer.

A separate bounds-check operation passes operand A through when it is below B, and traps otherwise.

Top module: `carry_adder_unit`

## Requirements
- R1: When `op_valid` is high at a rising clock edge, the operation is accepted and its outputs appear after that same edge. When `op_valid` is low at an edge, `res_valid` and `trap_req` are 0 after it and `carry_flag` keeps its value. Operation codes on `op_sel`: 0 checked add, 1 checked subtract, 2 chained add, 3 chained subtract, 4 plain add, 5 plain subtract, 6 tagged add, 7 tagged subtract, 8 bounds check.
- R2: Checked add (code 0) yields A + B + carry mod 2^32, clears the carry flag, and traps when the signed sum does not fit in 32 bits.
- R3: Checked subtract (code 1) yields A − B − carry mod 2^32, clears the carry flag, and traps when the signed difference does not fit in 32 bits.
- R4: Chained add (code 2) yields A + B + carry and loads the carry flag with bit 32 of the unsigned sum. It never traps.
- R5: Chained subtract (code 3) yields A − B − carry and loads the carry flag with the borrow, which is 1 exactly when unsigned A < B + carry. It never traps.
- R6: Plain add (code 4) yields A + B and plain subtract (code 5) yields A − B. Both ignore the carry flag, leave it unchanged, and never trap.
- R7: Tagged add (code 6) yields A + B and tagged subtract (code 7) yields A − B, ignoring the carry flag. They trap when bit 31 differs from bit 30 in either operand; otherwise they clear the carry flag.
- R8: Bounds check (code 8) compares A and B as unsigned numbers. When A < B it yields A and leaves the carry flag unchanged; otherwise it traps.
- R9: On any trap, `res_valid` is 0 and the carry flag is left unchanged. `res_valid` and `trap_req` are never high together.
- R10: Codes 9 to 15 produce no result and no trap, and leave the carry flag unchanged.
- R11: A synchronous active-high reset clears `carry_flag`, `res_valid`, `trap_req` and `res_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B |
| res_data | output | 32 | Result word, meaningful when `res_valid` is high |
| res_valid | output | 1 | Result produced by the last accepted operation |
| trap_req | output | 1 | The last accepted operation requests a trap |
| carry_flag | output | 1 | Current carry flag |

## Verification
The assertions check the following on every cycle:

- A trap and a result are never flagged together.
- Idle cycles emit nothing.
- A trap never disturbs the carry flag.
- Plain operations hold the flag.
- Checked and tagged operations leave the flag cleared unless they trap.
- Chained operations never trap.
- A bad tag always traps.
- A passing bounds check returns operand A.

Only the bench scenarios can show the arithmetic values themselves:

- Sums and differences with and without carry-in.
- The carry and borrow propagating across a two-word chain.
- The exact overflow boundaries at the signed limits.
- The unsigned ordering of the bounds compare near the top bit.
- The silence of undefined codes.

// File: rtl/cau_pkg.sv
package cau_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        OP_ADD_CHK = 4'd0,
        OP_SUB_CHK = 4'd1,
        OP_ADD_CHN = 4'd2,
        OP_SUB_CHN = 4'd3,
        OP_ADD_PLN = 4'd4,
        OP_SUB_PLN = 4'd5,
        OP_ADD_TAG = 4'd6,
        OP_SUB_TAG = 4'd7,
        OP_BOUND   = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        CM_KEEP  = 2'd0,
        CM_CLEAR = 2'd1,
        CM_COUT  = 2'd2,
        CM_NCOUT = 2'd3
    } carry_mode_e;

    typedef struct packed {
        logic        legal;
        logic        is_sub;
        logic        use_cin;
        logic        ovf_chk;
        logic        tag_chk;
        logic        bound;
        carry_mode_e cmode;
    } op_ctrl_t;

    function automatic op_ctrl_t decode_op(input logic [3:0] code);
        op_ctrl_t c;
        c = '{legal: 1'b1, is_sub: 1'b0, use_cin: 1'b0, ovf_chk: 1'b0,
              tag_chk: 1'b0, bound: 1'b0, cmode: CM_KEEP};
        case (code)
            OP_ADD_CHK: begin c.use_cin = 1'b1; c.ovf_chk = 1'b1; c.cmode = CM_CLEAR; end
            OP_SUB_CHK: begin c.is_sub = 1'b1; c.use_cin = 1'b1; c.ovf_chk = 1'b1; c.cmode = CM_CLEAR; end
            OP_ADD_CHN: begin c.use_cin = 1'b1; c.cmode = CM_COUT; end
            OP_SUB_CHN: begin c.is_sub = 1'b1; c.use_cin = 1'b1; c.cmode = CM_NCOUT; end
            OP_ADD_PLN: ;
            OP_SUB_PLN: c.is_sub = 1'b1;
            OP_ADD_TAG: begin c.tag_chk = 1'b1; c.cmode = CM_CLEAR; end
            OP_SUB_TAG: begin c.is_sub = 1'b1; c.tag_chk = 1'b1; c.cmode = CM_CLEAR; end
            OP_BOUND:   c.bound = 1'b1;
            default:    c.legal = 1'b0;
        endcase
        return c;
    endfunction

    // A word is a small integer only when its two top bits agree.
    function automatic logic tag_bad(input logic [WORD_W-1:0] w);
        return w[WORD_W-1] ^ w[WORD_W-2];
    endfunction

endpackage

// File: rtl/cau_adder.sv
module cau_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         ci_bit;
    logic [W:0]   total;

    always_comb begin
        b_eff  = sub ? ~b : b;
        // Subtract is A + ~B + 1 - carry, so the carry-in bit becomes ~carry.
        ci_bit = sub ? ~cin : cin;
        total  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, ci_bit};
        sum    = total[W-1:0];
        cout   = total[W];
        ovf    = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/cau_bound.sv
module cau_bound #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         below
);
    always_comb below = (a < b);
endmodule

// File: rtl/cau_policy.sv
module cau_policy
    import cau_pkg::*;
(
    input  op_ctrl_t ctrl,
    input  logic     carry_cur,
    input  logic     cout,
    input  logic     ovf,
    input  logic     tag_fail,
    input  logic     below,
    output logic     trap,
    output logic     emit,
    output logic     carry_nxt
);
    always_comb begin
        trap = ctrl.legal & ((ctrl.ovf_chk & ovf)
                           | (ctrl.tag_chk & tag_fail)
                           | (ctrl.bound & ~below));
        emit = ctrl.legal & ~trap;
        carry_nxt = carry_cur;
        if (emit) begin
            case (ctrl.cmode)
                CM_CLEAR: carry_nxt = 1'b0;
                CM_COUT:  carry_nxt = cout;
                CM_NCOUT: carry_nxt = ~cout;
                default:  carry_nxt = carry_cur;
            endcase
        end
    end
endmodule

// File: rtl/carry_adder_unit.sv
module carry_adder_unit
    import cau_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         op_valid,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] res_data,
    output logic         res_valid,
    output logic         trap_req,
    output logic         carry_flag
);
    op_ctrl_t     ctrl;
    logic [W-1:0] sum;
    logic         cout, ovf, below, tag_fail;
    logic         trap, emit, carry_nxt;
    logic [W-1:0] result;

    always_comb begin
        ctrl     = decode_op(op_sel);
        tag_fail = opnd_a[W-1] ^ opnd_a[W-2] ^ 1'b0 | (opnd_b[W-1] ^ opnd_b[W-2]);
    end

    cau_adder #(.W(W)) u_add (
        .a(opnd_a), .b(opnd_b), .sub(ctrl.is_sub),
        .cin(ctrl.use_cin & carry_flag),
        .sum(sum), .cout(cout), .ovf(ovf)
    );

    cau_bound #(.W(W)) u_bnd (.a(opnd_a), .b(opnd_b), .below(below));

    cau_policy u_pol (
        .ctrl(ctrl), .carry_cur(carry_flag), .cout(cout), .ovf(ovf),
        .tag_fail(tag_fail), .below(below),
        .trap(trap), .emit(emit), .carry_nxt(carry_nxt)
    );

    always_comb result = ctrl.bound ? opnd_a : sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_data   <= '0;
            res_valid  <= 1'b0;
            trap_req   <= 1'b0;
            carry_flag <= 1'b0;
        end else begin
            res_valid <= op_valid & emit;
            trap_req  <= op_valid & trap;
            if (op_valid) begin
                carry_flag <= carry_nxt;
                if (emit) res_data <= result;
            end
        end
    end
endmodule

// File: rtl/cau_checker.sv
module cau_checker
    import cau_pkg::*;
#(
    parameter int W = WORD_W
) (
    input logic         clk,
    input logic         rst,
    input logic         op_valid,
    input logic [3:0]   op_sel,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] res_data,
    input logic         res_valid,
    input logic         trap_req,
    input logic         carry_flag
);
    AST_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(res_valid && trap_req)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && !trap_req && $stable(carry_flag))); // R1

    AST_TRAP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
        trap_req |-> carry_flag == $past(carry_flag)); // R9

    AST_CHECKED_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_ADD_CHK || op_sel == OP_SUB_CHK))
        |=> (trap_req || !carry_flag)); // R2

    AST_TAGGED_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_ADD_TAG || op_sel == OP_SUB_TAG))
        |=> (trap_req || !carry_flag)); // R7

    AST_TAG_TRAPS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_ADD_TAG || op_sel == OP_SUB_TAG)
         && ((opnd_a[W-1] != opnd_a[W-2]) || (opnd_b[W-1] != opnd_b[W-2])))
        |=> trap_req); // R7

    AST_CHAIN_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_ADD_CHN || op_sel == OP_SUB_CHN))
        |=> !trap_req); // R4

    AST_PLAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_ADD_PLN || op_sel == OP_SUB_PLN))
        |=> ($stable(carry_flag) && !trap_req)); // R6

    AST_BOUND_PASS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_BOUND && opnd_a < opnd_b)
        |=> (res_valid && res_data == $past(opnd_a) && $stable(carry_flag))); // R8

    AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel > 4'd8)
        |=> (!res_valid && !trap_req && $stable(carry_flag))); // R10
endmodule

bind carry_adder_unit cau_checker #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_data(res_data),
    .res_valid(res_valid), .trap_req(trap_req), .carry_flag(carry_flag)
);

// File: tb/sim_carry_adder_unit.sv
module sim_carry_adder_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_sel;
    logic [31:0] opnd_a, opnd_b;
    logic [31:0] res_data;
    logic        res_valid, trap_req, carry_flag;

    int n_cmp = 0;
    int n_bad = 0;
    logic mc;       // bench copy of the carry flag
    logic [31:0] md; // bench copy of the last emitted result

    always #10 clk = ~clk; // 50 MHz

    carry_adder_unit u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_data(res_data),
        .res_valid(res_valid), .trap_req(trap_req), .carry_flag(carry_flag)
    );

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act v/t/c/data=%0b/%0b/%0b/%08h exp %0b/%0b/%0b/%08h",
                     req, act[34], act[33], act[32], act[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    // Expected {valid, trap, carry, data} worked out from the requirements.
    function automatic logic [34:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic c,
                                          input logic [31:0] last);
        logic [63:0] u;
        longint      s;
        logic        ci, ov, tr, nc, v;
        logic [31:0] r;
        ci = (op <= 4'd3) ? c : 1'b0;
        r = last; tr = 1'b0; nc = c; v = 1'b0;
        if (op <= 4'd7) begin
            if (op[0] == 1'b0) begin
                u = {32'd0, a} + {32'd0, b} + {63'd0, ci};
                s = longint'($signed(a)) + longint'($signed(b)) + longint'(ci);
            end else begin
                u = {32'd0, a} - {32'd0, b} - {63'd0, ci};
                s = longint'($signed(a)) - longint'($signed(b)) - longint'(ci);
            end
            ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            case (op)
                4'd0, 4'd1: begin tr = ov; nc = 1'b0; end
                4'd2:       nc = u[32];
                4'd3:       nc = u[63];
                4'd6, 4'd7: begin tr = (a[31] != a[30]) || (b[31] != b[30]); nc = 1'b0; end
                default:    ;
            endcase
            if (tr) nc = c;
            else begin v = 1'b1; r = u[31:0]; end
        end else if (op == 4'd8) begin
            if (a < b) begin v = 1'b1; r = a; end else tr = 1'b1;
        end
        return {v, tr, nc, r};
    endfunction

    task automatic run_op(input string req, input logic [3:0] op,
                          input logic [31:0] a, input logic [31:0] b);
        logic [34:0] e;
        @(negedge clk);
        op_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
        e = model(op, a, b, mc, md);
        @(negedge clk);
        op_valid = 1'b0;
        check(req, {res_valid, trap_req, carry_flag, res_data}, e);
        mc = e[32];
        if (e[34]) md = e[31:0];
    endtask

    task automatic idle_cycle(input string req);
        @(negedge clk);
        check(req, {res_valid, trap_req, carry_flag, res_data}, {1'b0, 1'b0, mc, md});
    endtask

    task automatic set_carry();
        run_op("R4_set", 4'd2, 32'hFFFF_FFFF, 32'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1; op_valid = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        mc = 1'b0; md = '0;
        check("R11", {res_valid, trap_req, carry_flag, res_data}, 35'd0);
    endtask

    task automatic t_checked();
        run_op("R2", 4'd0, 32'd100, 32'd23);
        set_carry();
        run_op("R2_cin", 4'd0, 32'd5, 32'd6);
        run_op("R2_ovf", 4'd0, 32'h7FFF_FFFF, 32'd1);
        run_op("R2_neg_ovf", 4'd0, 32'h8000_0000, 32'hFFFF_FFFF);
        run_op("R2_edge", 4'd0, 32'h7FFF_FFFE, 32'd1);
        run_op("R3", 4'd1, 32'd50, 32'd80);
        set_carry();
        run_op("R3_cin", 4'd1, 32'd10, 32'd3);
        run_op("R3_ovf", 4'd1, 32'h8000_0000, 32'd1);
        run_op("R3_ovf2", 4'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    endtask

    task automatic t_chain();
        // 64-bit add 0x00000001_FFFFFFF0 + 0x00000002_00000020
        run_op("R4_lo", 4'd2, 32'hFFFF_FFF0, 32'h0000_0020);
        run_op("R4_hi", 4'd2, 32'd1, 32'd2);
        run_op("R4_nocarry", 4'd2, 32'h7FFF_FFFF, 32'd1);
        // 64-bit subtract 0x5_00000000 - 0x1_00000001
        run_op("R5_lo", 4'd3, 32'd0, 32'd1);
        run_op("R5_hi", 4'd3, 32'd5, 32'd1);
        run_op("R5_eq_borrow", 4'd3, 32'd7, 32'd7);
        run_op("R5_eq_after", 4'd3, 32'd7, 32'd7);
    endtask

    task automatic t_plain();
        set_carry();
        run_op("R6_add", 4'd4, 32'hFFFF_FFFF, 32'd2);
        run_op("R6_sub", 4'd5, 32'd3, 32'd9);
        run_op("R6_ovf", 4'd4, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    endtask

    task automatic t_tag();
        set_carry();
        run_op("R7_add", 4'd6, 32'd40, 32'd2);
        set_carry();
        run_op("R7_sub", 4'd7, 32'hFFFF_FFF0, 32'd5);
        set_carry();
        run_op("R7_bad_a", 4'd6, 32'h4000_0000, 32'd1);
        run_op("R7_bad_b", 4'd7, 32'd1, 32'h8000_0001);
        run_op("R7_topneg_ok", 4'd6, 32'hC000_0000, 32'd0);
    endtask

    task automatic t_bound();
        set_carry();
        run_op("R8_pass", 4'd8, 32'd3, 32'd10);
        run_op("R8_equal", 4'd8, 32'd10, 32'd10);
        run_op("R8_unsigned", 4'd8, 32'h8000_0000, 32'd5);
        run_op("R8_unsigned_pass", 4'd8, 32'd5, 32'h8000_0000);
    endtask

    task automatic t_trap_carry();
        set_carry();
        run_op("R9_ovf_keeps", 4'd0, 32'h7FFF_FFFF, 32'd0);
        run_op("R9_tag_keeps", 4'd7, 32'h4000_0000, 32'd0);
    endtask

    task automatic t_undef();
        set_carry();
        for (int k = 9; k < 16; k++) run_op("R10", 4'(k), 32'd1, 32'd2);
        idle_cycle("R1_idle");
        run_op("R1_after_idle", 4'd4, 32'd1, 32'd1);
        idle_cycle("R1_idle2");
    endtask

    logic done = 1'b0;

    initial begin
        t_reset();
        t_checked();
        t_chain();
        t_plain();
        t_tag();
        t_bound();
        t_trap_carry();
        t_undef();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule